// File: doc/BRIEF.md
# Strided and Fragmented Payload Address Generator

This block turns a decoded transfer descriptor into the series of source read requests, each an address and a byte length, that a payload fetch engine issues to memory. A start pulse latches the descriptor fields. The block then presents one request at a time on a valid/ready handshake. When the walk is over it raises a one-cycle done pulse. The memory read and the storage of the returned data belong to the client.

Two walk modes exist. In line mode the block reads lines of a fixed size, each line a fixed stride after the one before, until the transfer size is used up. In fragment mode it visits up to five fragment base addresses. Each fragment runs from its address to the next 4 KiB page boundary. Each fragment address is 44 bits wide, built from a 32-bit base plus a 12-bit extension field taken from a shared extension word. The client reports a failed read on `rd_err`. That ends the walk at once and raises a data-error event.

Top module: `payload_addr_gen`

## Requirements
- R1: `mode_frag` is sampled at start: 0 selects line mode and 1 selects fragment mode.
- R2: `size_stride[17:0]` is the line size in bytes. `size_stride[31:18]` is the stride in units of 16 bytes.
- R3: In line mode, the first request address is the fragment-0 address. Each later request is one stride above the one before. Each length is the smaller of the line size and the remaining byte count. The walk ends when the remaining count reaches zero.
- R4: The fragment-0 address is `src_base[31:0]` plus `src_ext[27:16]` shifted left by 20. Fragment 1 adds `src_ext[43:32]`, the low 12 bits of word 1, shifted left by 8. Fragment 2 adds bits 27:16 of word 1 shifted left by 20. Fragment 3 adds bits 11:0 of word 2 shifted left by 8. Fragment 4 adds bits 27:16 of word 2 shifted left by 20. Base i is `src_base[32*i+31:32*i]`. All sums are 44 bits wide.
- R5: In fragment mode, each length is 4096 minus the address modulo 4096, trimmed to the remaining count. The walk ends when the total is reached or after the fifth fragment, whichever comes first.
- R6: `rd_err` high while a walk is running ends the walk. `done` and `data_err` go high on the next cycle and no further request is presented. The error wins over a request accepted in the same cycle.
- R7: In line mode, a zero line size with a nonzero transfer size presents no request. It gives `done` and `data_err` one cycle after start.
- R8: A zero transfer size presents no request. It gives `done` without `data_err` one cycle after start.
- R9: While `req_valid` is high and `req_ready` is low, `req_addr` and `req_len` hold their values.
- R10: All inputs are captured at start. A start pulse or an input change during a walk has no effect on the requests.
- R11: After reset, `req_valid`, `done` and `data_err` are low.
- R12: `done` is a one-cycle pulse, asserted in the cycle after the final request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| mode_frag | input | 1 | 0 line mode, 1 fragment mode |
| size_stride | input | 32 | Line size [17:0], stride in 16-byte units [31:18] |
| xfer_size | input | 32 | Total bytes to transfer |
| src_base | input | 160 | Five 32-bit fragment base addresses |
| src_ext | input | 96 | Three extension words |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted when high with valid |
| req_addr | output | 44 | Request source address |
| req_len | output | 32 | Request length in bytes |
| rd_err | input | 1 | Read failure reported by the client |
| done | output | 1 | Walk finished pulse |
| data_err | output | 1 | Data-error event pulse |

## Verification
The read-error abort and the acceptance of the final request can fall in the same cycle. The bench provokes this by driving `rd_err` and `req_ready` together on the only request of a single-line walk. It expects `done` and `data_err` both high on the next cycle, with no further request. A second case raises `rd_err` in the middle of a fragment walk, while the request is stalled. A start pulse carrying a different configuration during a walk is also applied, and the bench checks that the request sequence still follows the configuration captured at the first start.

// File: rtl/aw_pkg.sv
// Package: shared defaults and the walk-mode encoding for the payload
// address generator. Assumes nothing beyond standard SystemVerilog.
package aw_pkg;
    localparam int ADDR_W_DEF = 44;
    localparam int LEN_W_DEF  = 32;
    localparam int NFRAG_DEF  = 5;
    localparam int PAGE_W_DEF = 12;

    typedef enum logic {
        MODE_LINES = 1'b0,
        MODE_FRAGS = 1'b1
    } walk_mode_e;
endpackage

// File: rtl/aw_frag_addr.sv
// Module: aw_frag_addr
// Builds each fragment's wide address from its 32-bit base and a 12-bit
// extension field. Even fragments use bits 27:16 of their extension word
// shifted by 20. Odd fragments use bits 11:0 shifted by 8.
// Assumes NEXT = (NFRAG+1)/2 extension words. Purely combinational.
module aw_frag_addr #(
    parameter int ADDR_W = 44,
    parameter int NFRAG  = 5,
    parameter int NEXT   = (NFRAG + 1) / 2
) (
    input  logic [NFRAG*32-1:0]     bases,
    input  logic [NEXT*32-1:0]      exts,
    output logic [NFRAG*ADDR_W-1:0] frag_addr
);
    logic unused_exts;
    assign unused_exts = ^exts;

    // One adder per fragment; the extension field position depends on parity
    for (genvar i = 0; i < NFRAG; i++) begin : g_frag
        localparam int K = (i + 1) / 2;
        if (i % 2 == 0) begin : g_hi
            assign frag_addr[i*ADDR_W +: ADDR_W] =
                ADDR_W'(bases[i*32 +: 32]) + (ADDR_W'(exts[K*32+16 +: 12]) << 20);
        end else begin : g_lo
            assign frag_addr[i*ADDR_W +: ADDR_W] =
                ADDR_W'(bases[i*32 +: 32]) + (ADDR_W'(exts[K*32 +: 12]) << 8);
        end
    end
endmodule

// File: rtl/aw_len_calc.sv
// Module: aw_len_calc
// Computes the length of the current request. The raw length is the line
// size in line mode, or the distance to the next page boundary in fragment
// mode. The result is the raw length clipped to the remaining byte count.
// Purely combinational; assumes LEN_W > PAGE_W.
module aw_len_calc #(
    parameter int ADDR_W = 44,
    parameter int LEN_W  = 32,
    parameter int PAGE_W = 12
) (
    input  aw_pkg::walk_mode_e mode,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [LEN_W-1:0]   remaining,
    input  logic [17:0]        line_size,
    output logic [LEN_W-1:0]   req_len
);
    localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1) << PAGE_W;

    logic [LEN_W-1:0] page_len;
    logic [LEN_W-1:0] raw_len;
    logic unused_addr;
    assign unused_addr = ^cur_addr[ADDR_W-1:PAGE_W];

    // Pick the raw length for the mode, then clip it to what is left
    always_comb begin
        page_len = PAGE_BYTES - LEN_W'(cur_addr[PAGE_W-1:0]);
        raw_len  = (mode == aw_pkg::MODE_FRAGS) ? page_len : LEN_W'(line_size);
        req_len  = (raw_len < remaining) ? raw_len : remaining;
    end
endmodule

// File: rtl/aw_walk_ctrl.sv
// Module: aw_walk_ctrl
// Walk sequencer. At start it captures the configuration, then presents
// one request per handshake until the count is used up, the fragment list
// is exhausted, or a read error arrives. Assumes rd_err is meaningful only
// while busy.
module aw_walk_ctrl #(
    parameter int ADDR_W = 44,
    parameter int LEN_W  = 32,
    parameter int NFRAG  = 5,
    parameter int IDX_W  = $clog2(NFRAG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    mode_frag,
    input  logic [31:0]             size_stride,
    input  logic [LEN_W-1:0]        xfer_size,
    input  logic [NFRAG*ADDR_W-1:0] frag_addr,
    input  logic                    req_ready,
    input  logic                    rd_err,
    input  logic [LEN_W-1:0]        req_len,
    output logic                    busy,
    output aw_pkg::walk_mode_e      mode_q,
    output logic [ADDR_W-1:0]       cur_addr,
    output logic [LEN_W-1:0]        remaining,
    output logic [17:0]             line_q,
    output logic                    done,
    output logic                    data_err
);
    logic [ADDR_W-1:0] frag_q [NFRAG];
    logic [ADDR_W-1:0] stride_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  nxt_idx;
    logic              fire;
    logic              last_req;

    assign nxt_idx  = idx_q + 1'b1;
    assign fire     = busy && req_ready;
    assign last_req = (remaining == req_len) ||
                      (mode_q == aw_pkg::MODE_FRAGS && idx_q == IDX_W'(NFRAG - 1));

    // Sequencer: capture at start, advance on accept, abort on read error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            mode_q    <= aw_pkg::MODE_LINES;
            cur_addr  <= '0;
            remaining <= '0;
            line_q    <= '0;
            stride_q  <= '0;
            idx_q     <= '0;
            done      <= 1'b0;
            data_err  <= 1'b0;
            for (int i = 0; i < NFRAG; i++) frag_q[i] <= '0;
        end else begin
            done     <= 1'b0;
            data_err <= 1'b0;
            if (!busy) begin
                if (start) begin
                    mode_q    <= aw_pkg::walk_mode_e'(mode_frag);
                    line_q    <= size_stride[17:0];
                    stride_q  <= ADDR_W'(size_stride[31:18]) << 4;
                    remaining <= xfer_size;
                    cur_addr  <= frag_addr[0 +: ADDR_W];
                    idx_q     <= '0;
                    for (int i = 0; i < NFRAG; i++)
                        frag_q[i] <= frag_addr[i*ADDR_W +: ADDR_W];
                    if (xfer_size == '0) begin
                        done <= 1'b1;
                    end else if (!mode_frag && size_stride[17:0] == 18'd0) begin
                        done     <= 1'b1;
                        data_err <= 1'b1;
                    end else begin
                        busy <= 1'b1;
                    end
                end
            end else if (rd_err) begin
                busy     <= 1'b0;
                done     <= 1'b1;
                data_err <= 1'b1;
            end else if (fire) begin
                remaining <= remaining - req_len;
                if (last_req) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx_q    <= nxt_idx;
                    cur_addr <= (mode_q == aw_pkg::MODE_FRAGS) ? frag_q[nxt_idx]
                                                               : cur_addr + stride_q;
                end
            end
        end
    end
endmodule

// File: rtl/payload_addr_gen.sv
// Module: payload_addr_gen (top)
// Source read request generator for a descriptor-driven payload fetch.
// It joins the fragment address builder, the length calculator and the
// walk sequencer. Requests use a valid/ready handshake. Assumes the client
// reports read failures on rd_err while a walk runs.
module payload_addr_gen #(
    parameter int ADDR_W = aw_pkg::ADDR_W_DEF,
    parameter int LEN_W  = aw_pkg::LEN_W_DEF,
    parameter int NFRAG  = aw_pkg::NFRAG_DEF,
    parameter int PAGE_W = aw_pkg::PAGE_W_DEF,
    parameter int NEXT   = (NFRAG + 1) / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode_frag,
    input  logic [31:0]         size_stride,
    input  logic [LEN_W-1:0]    xfer_size,
    input  logic [NFRAG*32-1:0] src_base,
    input  logic [NEXT*32-1:0]  src_ext,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [LEN_W-1:0]    req_len,
    input  logic                rd_err,
    output logic                done,
    output logic                data_err
);
    logic [NFRAG*ADDR_W-1:0] frag_addr;
    logic                    busy;
    aw_pkg::walk_mode_e      mode_q;
    logic [ADDR_W-1:0]       cur_addr;
    logic [LEN_W-1:0]        remaining;
    logic [17:0]             line_q;

    aw_frag_addr #(.ADDR_W(ADDR_W), .NFRAG(NFRAG), .NEXT(NEXT)) u_frag (
        .bases     (src_base),
        .exts      (src_ext),
        .frag_addr (frag_addr)
    );

    aw_len_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_len (
        .mode      (mode_q),
        .cur_addr  (cur_addr),
        .remaining (remaining),
        .line_size (line_q),
        .req_len   (req_len)
    );

    aw_walk_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NFRAG(NFRAG)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode_frag   (mode_frag),
        .size_stride (size_stride),
        .xfer_size   (xfer_size),
        .frag_addr   (frag_addr),
        .req_ready   (req_ready),
        .rd_err      (rd_err),
        .req_len     (req_len),
        .busy        (busy),
        .mode_q      (mode_q),
        .cur_addr    (cur_addr),
        .remaining   (remaining),
        .line_q      (line_q),
        .done        (done),
        .data_err    (data_err)
    );

    assign req_valid = busy;
    assign req_addr  = cur_addr;
endmodule

// File: rtl/payload_addr_gen_chk.sv
// Module: payload_addr_gen_chk
// Property checker for payload_addr_gen, attached by bind. It keeps its own
// running byte total and fragment count for the walk in progress.
module payload_addr_gen_chk #(
    parameter int ADDR_W = 44,
    parameter int LEN_W  = 32,
    parameter int NFRAG  = 5,
    parameter int PAGE_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               mode_frag,
    input logic [31:0]        size_stride,
    input logic [LEN_W-1:0]   xfer_size,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [LEN_W-1:0]   req_len,
    input logic               rd_err,
    input logic               done,
    input logic               data_err,
    input logic               busy,
    input aw_pkg::walk_mode_e mode_q
);
    logic [LEN_W:0]   sum_q;
    logic [LEN_W-1:0] xfer_l;
    logic [7:0]       cnt_q;
    logic             fire;
    logic             unused_chk;

    assign fire       = req_valid && req_ready;
    assign unused_chk = ^{size_stride[31:18], req_addr[ADDR_W-1:PAGE_W]};

    // Track bytes and requests issued in the current walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            xfer_l <= '0;
            cnt_q  <= '0;
        end else if (start && !busy) begin
            sum_q  <= '0;
            xfer_l <= xfer_size;
            cnt_q  <= '0;
        end else if (fire && !rd_err) begin
            sum_q  <= sum_q + (LEN_W+1)'(req_len);
            cnt_q  <= cnt_q + 8'd1;
        end
    end

    // R9: a stalled request holds its address and length
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !rd_err) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

    // R5: a fragment request never crosses a page boundary
    a_r5_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_q == aw_pkg::MODE_FRAGS) |->
        ((LEN_W+1)'(req_addr[PAGE_W-1:0]) + (LEN_W+1)'(req_len) <= ((LEN_W+1)'(1) << PAGE_W)));

    // R5: no more than NFRAG fragment requests per walk
    a_r5_frag_count: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_q == aw_pkg::MODE_FRAGS) |-> (cnt_q < 8'(NFRAG)));

    // R3: the issued total never exceeds the transfer size
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (sum_q + (LEN_W+1)'(req_len) <= (LEN_W+1)'(xfer_l)));

    // R3: no zero-length request is ever presented
    a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0));

    // R6: a read error ends the walk with both pulses
    a_r6_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_err) |=> (done && data_err && !req_valid));

    // R7: zero line size in line mode fails at once
    a_r7_zero_line: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !mode_frag && size_stride[17:0] == 18'd0 && xfer_size != '0)
        |=> (done && data_err && !req_valid));

    // R12: the end of every walk is marked by done
    a_r12_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind payload_addr_gen payload_addr_gen_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NFRAG(NFRAG), .PAGE_W(PAGE_W)
) u_chk (.*);

// File: tb/tb_payload_addr_gen.sv
module tb_payload_addr_gen;
    localparam int ADDR_W = 44;
    localparam int LEN_W  = 32;
    localparam int NFRAG  = 5;
    localparam int NEXT   = 3;

    typedef struct packed {
        logic        mode;
        logic [17:0] line;
        logic [13:0] stride_u;
        logic [31:0] xfer;
        logic [31:0] base0;
        logic [31:0] ext0;
        logic [7:0]  exp_n;
        logic        exp_err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 18'd64,   14'd8,   32'd256,   32'h1000_0000, 32'h0005_0000, 8'd4, 1'b0},
        '{1'b0, 18'd100,  14'd10,  32'd250,   32'h0000_0040, 32'h0000_0000, 8'd3, 1'b0},
        '{1'b0, 18'd4096, 14'd256, 32'd4096,  32'h0000_2000, 32'h0000_0000, 8'd1, 1'b0},
        '{1'b1, 18'd0,    14'd0,   32'd10000, 32'h0000_0F00, 32'h0000_0000, 8'd5, 1'b0},
        '{1'b1, 18'd0,    14'd0,   32'd20000, 32'h0000_0F00, 32'h0000_0000, 8'd5, 1'b0},
        '{1'b1, 18'd0,    14'd0,   32'd1000,  32'h0000_0F00, 32'h0000_0000, 8'd2, 1'b0},
        '{1'b1, 18'd0,    14'd0,   32'd4096,  32'hF000_0000, 32'h0FFF_0000, 8'd1, 1'b0},
        '{1'b0, 18'd64,   14'd4,   32'd0,     32'h0000_0000, 32'h0000_0000, 8'd0, 1'b0},
        '{1'b0, 18'd0,    14'd4,   32'd5,     32'h0000_0000, 32'h0000_0000, 8'd0, 1'b1}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                mode_frag = 1'b0;
    logic [31:0]         size_stride = '0;
    logic [LEN_W-1:0]    xfer_size = '0;
    logic [NFRAG*32-1:0] src_base;
    logic [NEXT*32-1:0]  src_ext;
    logic                req_valid;
    logic                req_ready = 1'b0;
    logic [ADDR_W-1:0]   req_addr;
    logic [LEN_W-1:0]    req_len;
    logic                rd_err = 1'b0;
    logic                done;
    logic                data_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] exp_addr [64];
    logic [31:0] exp_len  [64];
    int          exp_cnt;

    payload_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_frag(mode_frag),
        .size_stride(size_stride), .xfer_size(xfer_size), .src_base(src_base),
        .src_ext(src_ext), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .rd_err(rd_err),
        .done(done), .data_err(data_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Fragment address from the stated field positions (R4)
    function automatic logic [63:0] frag_a(input int i);
        logic [31:0] b;
        logic [31:0] e;
        b = src_base[i*32 +: 32];
        e = src_ext[((i+1)/2)*32 +: 32];
        if (i % 2 == 0) return 64'(b) + (64'(e[27:16]) << 20);
        else            return 64'(b) + (64'(e[11:0]) << 8);
    endfunction

    // Expected request list from R3/R5
    task automatic build_expect(input vec_t v);
        logic [63:0] a;
        logic [31:0] rem;
        logic [31:0] l;
        exp_cnt = 0;
        rem = v.xfer;
        if (!v.mode) begin
            a = frag_a(0);
            if (v.line != 0) begin
                while (rem != 0 && exp_cnt < 64) begin
                    l = (32'(v.line) < rem) ? 32'(v.line) : rem;
                    exp_addr[exp_cnt] = a;
                    exp_len[exp_cnt] = l;
                    exp_cnt++;
                    rem -= l;
                    a += 64'(v.stride_u) * 16;
                end
            end
        end else begin
            for (int i = 0; i < NFRAG && rem != 0; i++) begin
                a = frag_a(i);
                l = 32'd4096 - 32'(a[11:0]);
                if (l > rem) l = rem;
                exp_addr[exp_cnt] = a;
                exp_len[exp_cnt] = l;
                exp_cnt++;
                rem -= l;
            end
        end
    endtask

    // Run one walk with a stalling ready pattern; optional restart attempt (R10)
    task automatic run_walk(input vec_t v, input bit poke_start);
        int got;
        bit seen_done;
        bit seen_err;
        bit stalled;
        logic [43:0] s_addr;
        logic [31:0] s_len;
        got = 0; seen_done = 0; seen_err = 0; stalled = 0;
        src_base[31:0] = v.base0;
        src_ext[31:0]  = v.ext0;
        build_expect(v);
        @(negedge clk);
        mode_frag   = v.mode;
        size_stride = {v.stride_u, v.line};
        xfer_size   = v.xfer;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 400 && !seen_done; c++) begin
            if (done) begin
                seen_done = 1;
                seen_err = data_err;
            end else if (req_valid) begin
                if (stalled)
                    chk(req_addr == s_addr && req_len == s_len, "R9", "held request",
                        64'(req_addr), 64'(s_addr));
                if (poke_start && c == 1) begin
                    start = 1'b1;
                    mode_frag = ~v.mode;
                    xfer_size = 32'd7;
                    size_stride = 32'h0004_0003;
                end else begin
                    start = 1'b0;
                end
                req_ready = (c % 3 != 2);
                stalled = !req_ready;
                s_addr = req_addr;
                s_len = req_len;
                if (req_ready) begin
                    if (got < exp_cnt) begin
                        chk(64'(req_addr) == exp_addr[got], v.mode ? "R4" : "R3", "address",
                            64'(req_addr), exp_addr[got]);
                        chk(req_len == exp_len[got], v.mode ? "R5" : "R3", "length",
                            64'(req_len), 64'(exp_len[got]));
                    end
                    got++;
                end
            end
            @(negedge clk);
            start = 1'b0;
            req_ready = 1'b0;
        end
        chk(seen_done, "R12", "done seen", 64'(seen_done), 64'd1);
        chk(got == int'(v.exp_n) && got == exp_cnt, "R5", "request count",
            64'(got), 64'(v.exp_n));
        chk(seen_err == v.exp_err, v.exp_err ? "R7" : "R8", "data_err",
            64'(seen_err), 64'(v.exp_err));
        @(negedge clk);
        chk(!done, "R12", "done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        vec_t v;
        int w;
        src_base = {32'h5000_0004, 32'h4000_0000, 32'h3000_0800, 32'h2000_0000, 32'h0};
        src_ext  = {32'h0000_0010, 32'h0001_0003, 32'h0};
        repeat (3) @(negedge clk);
        chk(!req_valid && !done && !data_err, "R11", "reset outputs",
            64'({req_valid, done, data_err}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk covers R1, R2, R3, R4, R5, R7, R8, R9, R12
        for (int i = 0; i < NV; i++) run_walk(VECS[i], 1'b0);

        // R10: start with a different configuration during a walk is ignored
        run_walk(VECS[3], 1'b1);
        run_walk(VECS[0], 1'b1);

        // R6: read error mid-walk while stalled
        v = VECS[3];
        src_base[31:0] = v.base0; src_ext[31:0] = v.ext0;
        mode_frag = v.mode; size_stride = '0; xfer_size = v.xfer;
        start = 1'b1; @(negedge clk); start = 1'b0;
        req_ready = 1'b1; @(negedge clk); @(negedge clk);
        req_ready = 1'b0; rd_err = 1'b1;
        @(negedge clk);
        rd_err = 1'b0;
        chk(done && data_err && !req_valid, "R6", "abort mid-walk",
            64'({done, data_err, req_valid}), 64'b110);
        w = 0;
        repeat (4) begin @(negedge clk); if (req_valid || done) w++; end
        chk(w == 0, "R6", "quiet after abort", 64'(w), 64'd0);

        // R6: error and final accept in the same cycle, error wins
        v = VECS[2];
        src_base[31:0] = v.base0; src_ext[31:0] = v.ext0;
        mode_frag = v.mode; size_stride = {v.stride_u, v.line}; xfer_size = v.xfer;
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(req_valid, "R6", "single request present", 64'(req_valid), 64'd1);
        req_ready = 1'b1; rd_err = 1'b1;
        @(negedge clk);
        req_ready = 1'b0; rd_err = 1'b0;
        chk(done && data_err && !req_valid, "R6", "error wins over accept",
            64'({done, data_err, req_valid}), 64'b110);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule